// File: doc/BRIEF.md
# Programmable Countdown Timer

A single memory-mapped down-counter with its own register file. Software programs a reload value, picks a counting mode (free-running, periodic or one-shot), a counter size (16 or 32 bits) and a prescale ratio (1, 16 or 256). It then sets the enable bit. The counter advances on the pre-divided `tick` clock enable. Each step that takes the counter from 1 to 0 raises a raw interrupt flag. The `irq` pin presents that flag gated by the interrupt-enable bit.

The register port is word addressed. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. There are two ways to set the reload value. The immediate path also reloads the counter. The deferred path only updates the stored value, and the counter picks it up the next time it wraps.

Control word bit map: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 wide (32-bit), bit 0 one-shot. Register offsets: 0 load-now, 1 current value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 deferred load.

Top module: `tmr_top`

## Requirements
- R1: The counter changes on a prescaled step only while control bit 7 (enable) is 1. With enable at 0 it holds its value whatever `tick` does.
- R2: Control bits 3:2 set the prescale ratio. Code 00 gives a step on every tick, 01 on every 16th tick and 10 on every 256th tick. Code 11 behaves like 00.
- R3: A step at value 0 reloads the counter when one-shot (bit 0) is clear. With periodic (bit 6) set, it reloads the stored value. A step from 1 to 0 sets the raw flag, so a periodic timer with value L signals every L+1 steps.
- R4: A write to offset 0 stores the reload value and loads it into the counter at the same edge. A write to offset 6 only stores the value, which the counter takes at its next wrap. Offsets 0 and 6 both read back the stored value.
- R5: When bits 6 and 0 are both clear (free-running), the counter reloads to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit), both at a wrap and on a write to offset 0, whatever the stored value.
- R6: Writes to offset 1 leave the counter unchanged. Any write to offset 3 clears the raw flag. If a set and a clear fall on the same edge, the flag ends up set.
- R7: Offset 4 reads the raw flag in bit 0. Offset 5 and the `irq` pin both equal the raw flag ANDed with bit 5 (interrupt enable).
- R8: After reset the control word is 0x20, and the stored value, the counter and the raw flag are all zero.
- R9: Reads of offset 3, offset 7 and any address at or above 8 return zero. Control reads back as the 8-bit word written, zero-extended.
- R10: With bit 0 (one-shot) set, the counter stops at 0 and stays there on further steps until it is reloaded.
- R11: With bit 1 clear, only the low 16 bits count and reload, and offset 1 reads zero in bits 31:16.
- R12: A control write that changes bits 3:2 restarts the prescale count, so the first step under the new ratio comes after a full ratio of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Pre-divided count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Word offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Masked interrupt |

## Verification
The bench drives exact tick counts so that it reaches the wrap points. It checks that periodic mode reloads the stored value and does not stop, that one-shot mode stays parked at zero, and that free-running mode jumps to all-ones instead of the stored value. A design that ignored the deferred path, or reloaded at once on it, shows the wrong value right after the offset-6 write. The bench changes the prescale ratio in the middle of a count, which exposes a prescaler that keeps its old count by stepping early. It also sets and clears the flag on the same edge, and writes in 16-bit mode with upper bits present, which catches a design that loses the interrupt or counts through the upper half.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W  = 32;
    localparam int HALF_W = 16;

    typedef struct packed {
        logic       en;        // bit 7
        logic       periodic;  // bit 6
        logic       ie;        // bit 5
        logic       spare;     // bit 4
        logic [1:0] pre;       // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } ctrl_t;

    typedef enum logic [2:0] {
        OFS_LOAD   = 3'd0,
        OFS_VALUE  = 3'd1,
        OFS_CTRL   = 3'd2,
        OFS_ICLR   = 3'd3,
        OFS_RAW    = 3'd4,
        OFS_MASKED = 3'd5,
        OFS_BGLOAD = 3'd6,
        OFS_SPARE  = 3'd7
    } reg_ofs_e;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, ie: 1'b1, spare: 1'b0,
                                   pre: 2'b00, wide: 1'b0, oneshot: 1'b0};

    // Keep only the active counter width.
    function automatic logic [TMR_W-1:0] fit(input logic [TMR_W-1:0] v, input logic wide);
        return wide ? v : {{(TMR_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    // Value the counter takes when it reloads under control word c.
    function automatic logic [TMR_W-1:0] refill(input ctrl_t c, input logic [TMR_W-1:0] ld);
        if (!c.periodic && !c.oneshot)
            return fit({TMR_W{1'b1}}, c.wide);
        return fit(ld, c.wide);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SHIFT_A = 4,
    parameter int SHIFT_B = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       step
);
    localparam int PW = SHIFT_B;
    localparam logic [PW-1:0] LIM_A = PW'((1 << SHIFT_A) - 1);
    localparam logic [PW-1:0] LIM_B = PW'((1 << SHIFT_B) - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        case (sel)
            2'b01:   lim = LIM_A;
            2'b10:   lim = LIM_B;
            default: lim = '0;
        endcase
    end

    assign step = tick && run && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (tick && run)
            cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             step,
    input  logic             load_now,
    input  logic [TMR_W-1:0] load_din,
    input  logic [TMR_W-1:0] reload_val,
    output logic [TMR_W-1:0] value,
    output logic             hit
);
    logic [TMR_W-1:0] cnt_q;

    assign value = fit(cnt_q, ctrl.wide);
    assign hit   = step && !load_now && (value == TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_now)
            cnt_q <= refill(ctrl, load_din);
        else if (step) begin
            if (value == '0)
                cnt_q <= ctrl.oneshot ? '0 : refill(ctrl, reload_val);
            else
                cnt_q <= fit(value - 1'b1, ctrl.wide);
        end
    end

endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PRE_SHIFT_A = 4,
    parameter int PRE_SHIFT_B = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_W-1:0]  wdata,
    output logic [TMR_W-1:0]  rd_data,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [TMR_W-1:0] load_q;
    logic             raw_q;
    logic [TMR_W-1:0] cnt_value;
    logic             zero_hit;
    logic             step;

    logic     in_map;
    reg_ofs_e ofs;
    logic     wr_load, wr_bg, wr_ctrl, wr_iclr, pre_restart;

    assign in_map  = ((addr >> 3) == '0);
    assign ofs     = reg_ofs_e'(addr[2:0]);
    assign wr_load = wr_en && in_map && (ofs == OFS_LOAD);
    assign wr_bg   = wr_en && in_map && (ofs == OFS_BGLOAD);
    assign wr_ctrl = wr_en && in_map && (ofs == OFS_CTRL);
    assign wr_iclr = wr_en && in_map && (ofs == OFS_ICLR);
    assign pre_restart = wr_ctrl && (wdata[3:2] != ctrl_q.pre);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[7:0]);
            if (wr_load || wr_bg)
                load_q <= wdata;
            if (zero_hit)
                raw_q <= 1'b1;
            else if (wr_iclr)
                raw_q <= 1'b0;
        end
    end

    tmr_prescaler #(
        .SHIFT_A(PRE_SHIFT_A),
        .SHIFT_B(PRE_SHIFT_B)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (ctrl_q.en),
        .sel    (ctrl_q.pre),
        .restart(pre_restart),
        .step   (step)
    );

    tmr_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .step      (step),
        .load_now  (wr_load),
        .load_din  (wdata),
        .reload_val(load_q),
        .value     (cnt_value),
        .hit       (zero_hit)
    );

    assign irq = raw_q && ctrl_q.ie;

    always_comb begin
        rd_data = '0;
        if (in_map) begin
            case (ofs)
                OFS_LOAD, OFS_BGLOAD: rd_data = load_q;
                OFS_VALUE:            rd_data = cnt_value;
                OFS_CTRL:             rd_data = {{(TMR_W-8){1'b0}}, ctrl_q};
                OFS_RAW:              rd_data = {{(TMR_W-1){1'b0}}, raw_q};
                OFS_MASKED:           rd_data = {{(TMR_W-1){1'b0}}, raw_q && ctrl_q.ie};
                default:              rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [TMR_W-1:0]  wdata,
    input logic [TMR_W-1:0]  rd_data,
    input logic              irq,
    input ctrl_t             ctrl,
    input logic [TMR_W-1:0]  value,
    input logic              raw
);
    assert_masked_read_R7: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(5)) |-> (rd_data == {{(TMR_W-1){1'b0}}, irq}));

    assert_oneshot_parked_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.oneshot && value == '0 && !wr_en) |=> (value == '0));

    assert_value_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(1) && !ctrl.en) |=> $stable(value));

    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(3) && !ctrl.en) |=> !raw);

    assert_load_now_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(0) && ctrl.periodic && ctrl.wide && !ctrl.oneshot)
        |=> (value == $past(wdata)));

    assert_hold_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !(wr_en && addr == ADDR_W'(0)) && !(wr_en && addr == ADDR_W'(2)))
        |=> $stable(value));

    assert_reset_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl == CTRL_RST && value == '0 && !raw));

endmodule

bind tmr_top tmr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rd_data(rd_data),
    .irq    (irq),
    .ctrl   (ctrl_q),
    .value  (cnt_value),
    .raw    (raw_q)
);

// File: tb/tmr_top_bench.sv
module tmr_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk, rst, tick, wr_en, irq;
    logic [AW-1:0] addr;
    logic [31:0]   wdata, rd_data;

    typedef struct {
        bit          pin;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic mon_req;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    tmr_top #(.ADDR_W(AW)) u_tmr_top (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops the expected item and compares mid-cycle.
    always @(negedge clk) begin : monitor
        exp_t        it;
        logic [31:0] act;
        if (mon_req) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual none expected item");
            end else begin
                it  = sb.pop_front();
                act = it.pin ? {31'b0, irq} : rd_data;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%h expected 0x%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic expect_item(input bit pin, input logic [AW-1:0] a,
                               input logic [31:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        addr = a;
        it.pin = pin; it.exp = e; it.tag = tag;
        sb.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        expect_item(1'b0, a, e, tag);
    endtask

    task automatic pin(input logic e, input string tag);
        expect_item(1'b1, '0, {31'b0, e}, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; mon_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        rd(4'd2, 32'h20, "R8 control after reset");
        rd(4'd0, 32'h0,  "R8 load after reset");
        rd(4'd1, 32'h0,  "R8 value after reset");
        rd(4'd4, 32'h0,  "R8 raw after reset");
        pin(1'b0, "R7 irq after reset");

        // Immediate load, enable gating
        wr(4'd2, 32'h62);
        wr(4'd0, 32'd5);
        rd(4'd1, 32'd5, "R4 load-now value");
        rd(4'd3, 32'h0, "R9 clear offset reads zero");
        rd(4'd7, 32'h0, "R9 offset 7 reads zero");
        rd(4'd12, 32'h0, "R9 unmapped reads zero");
        ticks(3);
        rd(4'd1, 32'd5, "R1 disabled holds");

        // Periodic count and wrap
        wr(4'd2, 32'hE2);
        rd(4'd2, 32'hE2, "R9 control readback");
        ticks(4);
        rd(4'd1, 32'd1, "R3 counted to one");
        rd(4'd4, 32'h0, "R3 no flag before zero");
        ticks(1);
        rd(4'd1, 32'd0, "R3 reached zero");
        rd(4'd4, 32'h1, "R3 flag at zero");
        rd(4'd5, 32'h1, "R7 masked with ie");
        pin(1'b1, "R7 irq with ie");
        ticks(1);
        rd(4'd1, 32'd5, "R3 periodic reload");

        // Deferred load
        wr(4'd6, 32'd9);
        rd(4'd1, 32'd5, "R4 deferred leaves counter");
        rd(4'd0, 32'd9, "R4 offset 0 shows stored");
        rd(4'd6, 32'd9, "R4 offset 6 shows stored");
        ticks(6);
        rd(4'd1, 32'd9, "R4 deferred taken at wrap");

        // Clear and ignored value write (tick idle, counter still)
        wr(4'd3, 32'h0);
        rd(4'd4, 32'h0, "R6 clear");
        pin(1'b0, "R7 irq after clear");
        wr(4'd1, 32'h1234);
        rd(4'd1, 32'd9, "R6 value write ignored");

        // Interrupt enable off
        wr(4'd2, 32'hC2);
        ticks(9);
        rd(4'd1, 32'd0, "R3 second period");
        rd(4'd4, 32'h1, "R7 raw without ie");
        rd(4'd5, 32'h0, "R7 masked without ie");
        pin(1'b0, "R7 irq without ie");

        // Set and clear on the same edge
        wr(4'd3, 32'h0);
        ticks(9);
        rd(4'd1, 32'd1, "R6 setup one");
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 4'd3; tick = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0;
        rd(4'd4, 32'h1, "R6 set wins over clear");
        wr(4'd3, 32'h0);

        // One-shot
        wr(4'd2, 32'h83);
        wr(4'd0, 32'd2);
        rd(4'd1, 32'd2, "R10 one-shot load");
        ticks(2);
        rd(4'd4, 32'h1, "R10 one-shot flag");
        ticks(3);
        rd(4'd1, 32'd0, "R10 one-shot parked");

        // Free-running 32-bit
        wr(4'd2, 32'h82);
        ticks(1);
        rd(4'd1, 32'hFFFF_FFFF, "R5 free 32-bit wrap");
        ticks(1);
        rd(4'd1, 32'hFFFF_FFFE, "R5 free 32-bit counts");

        // Free-running 16-bit
        wr(4'd2, 32'h83);
        wr(4'd0, 32'd1);
        ticks(1);
        wr(4'd2, 32'h80);
        ticks(1);
        rd(4'd1, 32'h0000_FFFF, "R5 free 16-bit wrap");

        // Periodic 16-bit
        wr(4'd2, 32'hC0);
        wr(4'd3, 32'h0);
        wr(4'd0, 32'h0001_0003);
        rd(4'd1, 32'd3, "R11 16-bit load low half");
        rd(4'd0, 32'h0001_0003, "R11 stored value full width");
        ticks(2);
        rd(4'd4, 32'h0, "R11 no early flag");
        ticks(1);
        rd(4'd4, 32'h1, "R11 flag at low-half zero");
        ticks(1);
        rd(4'd1, 32'd3, "R11 16-bit reload");

        // Prescale
        wr(4'd2, 32'h42);
        wr(4'd0, 32'd40);
        wr(4'd2, 32'hC6);
        ticks(15);
        rd(4'd1, 32'd40, "R2 div16 before step");
        ticks(1);
        rd(4'd1, 32'd39, "R2 div16 step");
        ticks(10);
        wr(4'd2, 32'hCA);
        ticks(255);
        rd(4'd1, 32'd39, "R12 restart no early step");
        ticks(1);
        rd(4'd1, 32'd38, "R12 div256 step");
        wr(4'd2, 32'hCE);
        ticks(1);
        rd(4'd1, 32'd37, "R2 code 11 per tick");

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule